// File: doc/BRIEF.md
# SPI Serial Memory with Block Write Protection

This block is the SPI slave side of a 512-byte memory kept as an internal register array. A host reads bytes, writes pages of up to 16 bytes, and reads or writes a small status register. Every change to storage is guarded in three ways. A write-enable latch must be set first. A region code can fence off none, the top quarter, the top half or the whole array. An active-low protect pin freezes the region code. An accepted write does not land at once. It runs as a self-timed cycle measured by a counter, and the block reports busy until the cycle ends. While busy it answers only status reads.

The serial pins are brought into the system clock domain through synchronizers, so SCK has to run several times slower than `clk`. Input bits are taken on rising SCK and output bits change on falling SCK. Modes 0 and 3 both work this way. The control path is one state machine. ST_IDLE goes to ST_OPCODE when chip-select falls. When the first byte is complete, ST_OPCODE moves to one of these: ST_STAT_RD for a status read, ST_STAT_WR for an accepted status write, ST_RADDR for a read, ST_WADDR for an accepted write, or ST_IGNORE for anything refused. Some states step forward after one more byte: ST_RADDR to ST_READ, ST_WADDR to ST_WDATA, and ST_STAT_WR to ST_STAT_HOLD. Whenever chip-select goes high, every state returns to ST_IDLE. The timed cycle can only begin at that moment, from ST_WDATA or ST_STAT_HOLD.

Top module: `spi_guarded_mem`

## Requirements
- R1: A read uses opcode 0x03 with byte-address bit 8 in opcode bit 3, followed by one byte carrying address bits 7:0. Data then comes out MSB first, and the address steps up after each byte, wrapping from 0x1FF to 0x000. After reset every byte reads 0xFF.
- R2: Bits are taken on rising SCK and the output changes on falling SCK. The first data bit is valid before the first rising edge of the data byte. While chip-select is high, MISO is high-impedance.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. A memory write or status write sent while the latch is clear has no effect.
- R4: Status read opcode 0x05 returns the status byte on every following byte of the transfer. The status byte is: bit 0 busy, bit 1 write-enable latch, bits 3:2 region code, bits 7:4 zero. It reads 0x00 after reset.
- R5: A write uses opcode 0x02 with address bit 8 in opcode bit 3, then one address byte, then data bytes. Byte positions wrap inside the 16-byte aligned page. A later byte at the same position replaces an earlier one.
- R6: A memory write is carried out only if chip-select rises on a whole-byte boundary after at least one data byte. Otherwise storage is unchanged, no busy cycle starts and the latch stays set.
- R7: The region code protects nothing (00), addresses 0x180 and up (01), addresses 0x100 and up (10), or all addresses (11). A write to a protected page changes nothing, starts no busy cycle and leaves the latch set.
- R8: Status write opcode 0x01 takes the region code from data bits 3:2. While wp_n is low, a status write is refused and the code is kept.
- R9: An accepted write holds status bit 0 high for WRITE_CYCLES clocks. When the cycle ends, the data or region code takes effect and the latch clears.
- R10: While busy, every command except a status read is ignored, including writes sent while the latch is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 or 3 |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out, high-impedance while deselected |
| wp_n | input | 1 | Active-low protect pin for the status register |

## Verification
The bench writes every region code and then tries a write into each quarter of the array, covering all sixteen pairs. This separates a correct region decode from one that is off by a quarter or uses the wrong comparison. Writes are tried with a full page, with an offset that wraps inside the page, with a trailing partial byte, with no data byte, while busy and while the latch is clear. Each case shows whether commit is gated by the right condition. A final continuous read across the 0x1FF boundary is compared with a model kept in the bench. It confirms every accepted write, every refused write and the address wrap together.

// File: rtl/sgm_pkg.sv
package sgm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_RADDR,
        ST_READ,
        ST_WADDR,
        ST_WDATA,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_STAT_HOLD,
        ST_IGNORE
    } fsm_state_t;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    // low three opcode bits; bit 3 carries address bit 8
    localparam logic [2:0] OPL_READ  = 3'b011;
    localparam logic [2:0] OPL_WRITE = 3'b010;

    typedef struct packed {
        logic [3:0] zero;
        logic [1:0] region;
        logic       wel;
        logic       wip;
    } status_t;

    // top: the two most significant address bits of a page
    function automatic logic in_protected(input logic [1:0] code, input logic [1:0] top);
        logic hit;
        case (code)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top == 2'b11);
            2'b10:   hit = top[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/sgm_pin_sync.sv
module sgm_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] prev_out
);
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic [STAGES:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {(STAGES+1){RST_VAL[gi]}};
            end else begin
                chain <= {chain[STAGES-1:0], async_in[gi]};
            end
        end
        assign sync_out[gi] = chain[STAGES-1];
        assign prev_out[gi] = chain[STAGES];
    end
endmodule

// File: rtl/sgm_write_timer.sv
module sgm_write_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start && remain == '0) begin
            remain <= CW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
    assign done = (remain == CW'(1));
endmodule

// File: rtl/sgm_page_store.sv
module sgm_page_store #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16,
    localparam int LANE_W    = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              stg_clr,
    input  logic              stg_we,
    input  logic [LANE_W-1:0] stg_lane,
    input  logic [7:0]        stg_data,
    input  logic              commit,
    input  logic [PAGE_W-1:0] commit_page,
    output logic              any_staged
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask;

    // staging buffer: one byte per page position plus a fill mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
        end else if (stg_clr) begin
            mask <= '0;
        end else if (stg_we) begin
            pbuf[stg_lane] <= stg_data;
            mask[stg_lane] <= 1'b1;
        end
    end

    // array: erased to all ones, whole page committed in one clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask[i]) mem[{commit_page, LANE_W'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data    = mem[rd_addr];
    assign any_staged = |mask;
endmodule

// File: rtl/spi_guarded_mem.sv
module spi_guarded_mem #(
    parameter int ADDR_W       = 9,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 200,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    input  logic wp_n
);
    import sgm_pkg::*;

    localparam int LANE_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - LANE_W;

    // ---------------- pin synchronisation and edges ----------------
    logic [2:0] pin_now, pin_prev;

    sgm_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({spi_mosi, spi_sck, spi_cs_n}),
        .sync_out(pin_now),
        .prev_out(pin_prev)
    );

    logic cs_act, cs_fall_p, cs_rise_p, sck_rise, sck_fall, mosi_s;
    assign cs_act    = ~pin_now[0];
    assign cs_fall_p = ~pin_now[0] &  pin_prev[0];
    assign cs_rise_p =  pin_now[0] & ~pin_prev[0];
    assign sck_rise  =  pin_now[1] & ~pin_prev[1];
    assign sck_fall  = ~pin_now[1] &  pin_prev[1];
    assign mosi_s    =  pin_now[2];

    // ---------------- declarations ----------------
    fsm_state_t        state, state_nx, op_target;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sh;
    logic [7:0]        rx_byte;
    logic              byte_done, op_byte;
    logic              wel, op_a8, cycle_is_status;
    logic [1:0]        region, pend_region, wr_region;
    logic [ADDR_W-1:0] rd_ptr, rd_addr;
    logic [PAGE_W-1:0] wr_page;
    logic [LANE_W-1:0] wr_lane;
    logic [7:0]        tx_sh, rd_data;
    logic              so_q;
    logic              wr_busy, wr_done, cycle_start, commit_data;
    logic              stg_clr, stg_we, any_staged;
    status_t           stat;

    assign rx_byte   = {rx_sh, mosi_s};
    assign byte_done = cs_act && sck_rise && (bit_cnt == 3'd7);
    assign op_byte   = byte_done && (state == ST_OPCODE);
    assign wr_region = wr_page[PAGE_W-1 -: 2];

    always_comb begin
        stat        = '0;
        stat.region = region;
        stat.wel    = wel;
        stat.wip    = wr_busy;
    end

    // ---------------- opcode decode ----------------
    always_comb begin
        if (wr_busy && rx_byte != OP_RDSR) begin
            op_target = ST_IGNORE;
        end else if (rx_byte == OP_RDSR) begin
            op_target = ST_STAT_RD;
        end else if (rx_byte == OP_WRSR) begin
            op_target = (wel && wp_n) ? ST_STAT_WR : ST_IGNORE;
        end else if (rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OPL_READ) begin
            op_target = ST_RADDR;
        end else if (rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OPL_WRITE) begin
            op_target = wel ? ST_WADDR : ST_IGNORE;
        end else begin
            op_target = ST_IGNORE;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        if (!cs_act) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      if (cs_fall_p) state_nx = ST_OPCODE;
                ST_OPCODE:    if (byte_done) state_nx = op_target;
                ST_RADDR:     if (byte_done) state_nx = ST_READ;
                ST_WADDR:     if (byte_done) state_nx = ST_WDATA;
                ST_STAT_WR:   if (byte_done) state_nx = ST_STAT_HOLD;
                ST_READ,
                ST_WDATA,
                ST_STAT_RD,
                ST_STAT_HOLD,
                ST_IGNORE:    state_nx = state;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- store and cycle control ----------------
    assign rd_addr     = (state == ST_RADDR) ? {op_a8, rx_byte} : rd_ptr;
    assign stg_clr     = op_byte && (op_target == ST_WADDR);
    assign stg_we      = byte_done && (state == ST_WDATA);
    assign cycle_start = cs_rise_p && (bit_cnt == 3'd0) && !wr_busy &&
                         ((state == ST_WDATA && any_staged && !in_protected(region, wr_region)) ||
                          state == ST_STAT_HOLD);
    assign commit_data = wr_done && !cycle_is_status;

    sgm_write_timer #(
        .CYCLES(WRITE_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(cycle_start),
        .busy (wr_busy),
        .done (wr_done)
    );

    sgm_page_store #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .stg_clr    (stg_clr),
        .stg_we     (stg_we),
        .stg_lane   (wr_lane),
        .stg_data   (rx_byte),
        .commit     (commit_data),
        .commit_page(wr_page),
        .any_staged (any_staged)
    );

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt         <= '0;
            rx_sh           <= '0;
            wel             <= 1'b0;
            op_a8           <= 1'b0;
            region          <= 2'b00;
            pend_region     <= 2'b00;
            cycle_is_status <= 1'b0;
            rd_ptr          <= '0;
            wr_page         <= '0;
            wr_lane         <= '0;
            tx_sh           <= '0;
            so_q            <= 1'b0;
        end else begin
            if (!cs_act)       bit_cnt <= '0;
            else if (sck_rise) bit_cnt <= bit_cnt + 1'b1;

            if (cs_act && sck_rise) rx_sh <= {rx_sh[5:0], mosi_s};

            if (wr_done) begin
                wel <= 1'b0;
            end else if (op_byte && !wr_busy) begin
                if (rx_byte == OP_WREN)      wel <= 1'b1;
                else if (rx_byte == OP_WRDI) wel <= 1'b0;
            end

            if (op_byte) op_a8 <= rx_byte[3];

            if (byte_done && state == ST_STAT_WR) pend_region <= rx_byte[3:2];
            if (wr_done && cycle_is_status)       region      <= pend_region;
            if (cycle_start) cycle_is_status <= (state == ST_STAT_HOLD);

            if (byte_done && state == ST_WADDR) begin
                wr_page <= {op_a8, rx_byte[7:LANE_W]};
                wr_lane <= rx_byte[LANE_W-1:0];
            end else if (stg_we) begin
                wr_lane <= wr_lane + 1'b1;
            end

            if (byte_done && (state == ST_STAT_RD || (op_byte && op_target == ST_STAT_RD))) begin
                tx_sh <= stat;
            end else if (byte_done && (state == ST_RADDR || state == ST_READ)) begin
                tx_sh  <= rd_data;
                rd_ptr <= rd_addr + 1'b1;
            end else if (cs_act && sck_fall) begin
                so_q  <= tx_sh[7];
                tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    assign spi_miso = cs_act ? so_q : 1'bz;

endmodule

// File: rtl/spi_guarded_mem_chk.sv
module spi_guarded_mem_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wel,
    input logic [1:0] region,
    input logic       commit,
    input logic [1:0] page_top,
    input logic       cycle_start
);
    import sgm_pkg::*;

    // R9: latch stays set through the whole timed cycle
    p_wel_held_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wel);

    // R9: latch is clear once the cycle has ended
    p_wel_clear_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R9: an accepted start is followed by busy
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> busy);

    // R7: no committed page lies in a protected region
    p_no_protected_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !in_protected(region, page_top));

    // R8: the region code only changes as a cycle ends
    p_region_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(region) |-> $fell(busy));

    // R10: no new cycle is started while one is running
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cycle_start);
endmodule

bind spi_guarded_mem spi_guarded_mem_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (wr_busy),
    .wel        (wel),
    .region     (region),
    .commit     (commit_data),
    .page_top   (wr_region),
    .cycle_start(cycle_start)
);

// File: tb/spi_guarded_mem_test.sv
`timescale 1ns/1ps
module spi_guarded_mem_test;
    localparam int WC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [512];
    logic [7:0] rxv;

    always #2.5 clk = ~clk;

    spi_guarded_mem #(.WRITE_CYCLES(WC)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .wp_n(wp_n)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (4) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_on();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic one_op(input logic [7:0] op);
        logic [7:0] d;
        cs_on(); xfer(op, d); cs_off();
    endtask

    task automatic get_status(output logic [7:0] s);
        logic [7:0] d;
        cs_on(); xfer(8'h05, d); xfer(8'h00, s); cs_off();
    endtask

    task automatic expect_status(input logic [7:0] exp, input string req);
        logic [7:0] s;
        get_status(s);
        check(s === exp, req, {8'h0, s}, {8'h0, exp});
    endtask

    task automatic set_region(input logic [7:0] v);
        logic [7:0] d;
        cs_on(); xfer(8'h01, d); xfer(v, d); cs_off();
    endtask

    function automatic logic [7:0] dat(input int a, input int seed);
        return 8'((a * 13 + seed * 29 + 5) & 255);
    endfunction

    // writes n bytes from addr (positions wrap in page); apply updates the model
    task automatic write_mem(input int addr, input int n, input int seed, input bit apply);
        logic [7:0] d;
        int a;
        cs_on();
        xfer({4'h0, 1'(addr >> 8), 3'b010}, d);
        xfer(8'(addr), d);
        for (int k = 0; k < n; k++) begin
            a = (addr & 'h1F0) | ((addr + k) & 'hF);
            xfer(dat(a, seed), d);
            if (apply) shadow[a] = dat(a, seed);
        end
        cs_off();
    endtask

    task automatic read_check(input int addr, input int n, input string req);
        logic [7:0] d;
        int a;
        cs_on();
        xfer({4'h0, 1'(addr >> 8), 3'b011}, d);
        xfer(8'(addr), d);
        for (int k = 0; k < n; k++) begin
            a = (addr + k) % 512;
            xfer(8'h00, d);
            check(d === shadow[a], req, {7'h0, 9'(a)} ^ {8'h0, d} ^ {7'h0, 9'(a)}, {8'h0, shadow[a]});
        end
        cs_off();
    endtask

    task automatic wait_cycle();
        repeat (WC + 40) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 512; i++) shadow[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: deselected output is high-impedance; R4: reset status
        check(miso === 1'bz, "R2 miso z at reset", {15'h0, miso}, 16'h0);
        expect_status(8'h00, "R4 reset status");
        read_check(0, 4, "R1 erased read");

        // R3: write with latch clear is ignored
        write_mem('h010, 2, 1, 0);
        expect_status(8'h00, "R3 no busy without latch");
        read_check('h010, 2, "R3 data unchanged without latch");

        // R3/R4: latch set and clear
        one_op(8'h06);
        expect_status(8'h02, "R3 latch set");
        one_op(8'h04);
        expect_status(8'h00, "R3 latch cleared");

        // R5/R9: full page write and timed cycle
        one_op(8'h06);
        write_mem('h020, 16, 2, 1);
        expect_status(8'h03, "R9 busy after write");
        wait_cycle();
        expect_status(8'h00, "R9 idle and latch clear after cycle");
        read_check('h020, 16, "R5 full page");

        // R5: wrap inside page, upper half via opcode bit 3
        one_op(8'h06);
        write_mem('h13E, 4, 3, 1);
        wait_cycle();
        read_check('h130, 16, "R5 in-page wrap");

        // R6: partial trailing byte, then no data byte
        one_op(8'h06);
        cs_on();
        xfer(8'h02, d); xfer(8'h50, d); xfer(8'hAA, d);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1; repeat (4) @(negedge clk);
            sck = 1'b1; repeat (4) @(negedge clk); sck = 1'b0;
        end
        cs_off();
        expect_status(8'h02, "R6 partial byte refused");
        cs_on(); xfer(8'h02, d); xfer(8'h58, d); cs_off();
        expect_status(8'h02, "R6 empty write refused");
        read_check('h050, 16, "R6 storage unchanged");
        one_op(8'h04);

        // R10: commands during busy are ignored
        one_op(8'h06);
        write_mem('h060, 1, 4, 1);
        expect_status(8'h03, "R10 busy status readable");
        write_mem('h070, 1, 5, 0);
        wait_cycle();
        expect_status(8'h00, "R10 no second cycle");
        read_check('h060, 1, "R10 first write landed");
        read_check('h070, 1, "R10 busy write ignored");

        // R8: protect pin blocks status write
        wp_n = 1'b0;
        one_op(8'h06);
        set_region(8'h0C);
        expect_status(8'h02, "R8 pin blocks status write");
        wp_n = 1'b1;
        one_op(8'h04);

        // R7/R8: every region code against every quarter
        for (int bp = 0; bp < 4; bp++) begin
            one_op(8'h06);
            set_region(8'(bp << 2));
            wait_cycle();
            expect_status(8'(bp << 2), "R8 region code written");
            for (int q = 0; q < 4; q++) begin
                bit prot;
                prot = (bp == 3) || (bp == 2 && q >= 2) || (bp == 1 && q == 3);
                one_op(8'h06);
                write_mem(q * 128 + 16 * bp + 3, 1, bp * 4 + q + 10, !prot);
                expect_status(prot ? 8'((bp << 2) | 2) : 8'((bp << 2) | 3), "R7 protection decision");
                wait_cycle();
                one_op(8'h04);
                read_check(q * 128 + 16 * bp + 3, 1, "R7 region content");
            end
        end

        // R1: continuous read across the top of the array
        read_check('h1FE, 514, "R1 full read with wrap");
        repeat (2) @(negedge clk);
        check(miso === 1'bz, "R2 miso z after deselect", {15'h0, miso}, 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule